// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block translates instruction fetch addresses from effective to real addresses through a small direct-mapped table. Each slot is chosen by folding three slices of the page number together with XOR. This spreads the pages of a large program over the table better than indexing by the low page bits alone. A fetch stage presents an effective address. One cycle later the block returns a real address, or a fail flag that the downstream pipeline turns into a fetch exception.

Two mode flags control translation. The virtual flag turns translation on or off. The privilege flag marks supervisor state. Both flags are captured only when a fetch redirect arrives. A page-table walker installs entries, and the block refuses any entry whose permission bits could never allow execution. Flush logic can clear one slot, chosen by address, or the whole table.

Top module: `itlb_hashed_dm`

## Requirements
- R1: While reset is applied and after it is released, `rsp_valid` is low. Every slot starts empty, so the first translated lookup fails. The reset mode is untranslated and privileged.
- R2: For a lookup in untranslated mode, the response gives `rsp_ra` equal to the low RA_W bits of the effective address, with `rsp_fail` low. No table state is consulted.
- R3: The slot index is (ea[17:12] XOR ea[23:18] XOR ea[29:24]) with the default 64 slots. An installed entry replaces whatever occupied its slot, so two pages with the same index displace each other.
- R4: A translated lookup hits when its slot is valid and the stored tag equals ea[63:12]. The response is then `rsp_ra` = {pte[55:12], ea[11:0]} with `rsp_fail` low.
- R5: A translated lookup that misses gives `rsp_fail` high and `rsp_ra` zero.
- R6: If the hit entry has pte bit 3 (supervisor-only) set and the privilege flag is 0, the lookup fails even though it hit.
- R7: An install request is ignored when pte bit 0 (execute allowed) is 0 or pte bit 8 (referenced) is 0.
- R8: A single invalidate clears the slot at the hashed index of `inv_ea`, without comparing that slot's tag.
- R9: `inv_all` empties every slot. When it is asserted in the same cycle as an install or a single invalidate, it takes precedence.
- R10: The mode flags change only when `redirect` is high. A lookup in the same cycle as a redirect uses the new flags. When `redirect` is low, the values on `redir_virt` and `redir_priv` have no effect.
- R11: A lookup in the same cycle as a table write sees the contents from before that write. A single invalidate in the same cycle as an install to the same slot leaves that slot empty.
- R12: `rsp_valid` is `req_valid` delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| redirect | input | 1 | Fetch redirect; captures the mode flags |
| redir_virt | input | 1 | Translation enable carried by the redirect |
| redir_priv | input | 1 | Privilege state carried by the redirect (1 = supervisor) |
| req_valid | input | 1 | Lookup request |
| req_ea | input | EA_W (64) | Effective fetch address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_ra | output | RA_W (56) | Real address |
| rsp_fail | output | 1 | Fetch failed (miss or privilege violation) |
| ins_valid | input | 1 | Install request from the walker |
| ins_ea | input | EA_W (64) | Effective address of the page being installed |
| ins_pte | input | 64 | Page table entry being installed |
| inv_valid | input | 1 | Single-slot invalidate |
| inv_ea | input | EA_W (64) | Address whose hashed slot is invalidated |
| inv_all | input | 1 | Whole-table invalidate |

## Verification
The bench uses the default parameters: 64 slots, 4 KiB pages, 64-bit effective and 56-bit real addresses. These values make the three-field fold concrete. Two pages that differ only in bits 12 and 18 collide in the same slot, which lets the bench show displacement and tag-blind invalidation on a real alias. The full 56-bit real page path is exercised with non-trivial page numbers. The same-cycle orderings between install, invalidate, whole flush, redirect and lookup are each driven on purpose and checked against a behavioural model.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int PTE_EXEC_BIT = 0;
  localparam int PTE_PRIV_BIT = 3;
  localparam int PTE_REF_BIT  = 8;

  typedef struct packed {
    logic virt;
    logic priv;
  } fmode_t;
endpackage

// File: rtl/itlb_hash.sv
module itlb_hash #(
  parameter int IDX_W = 6,
  parameter int NFOLD = 3,
  localparam int HW = IDX_W * NFOLD
) (
  input  logic [HW-1:0]    vpn_lo,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int k = 0; k < NFOLD; k++) begin
      idx = idx ^ vpn_lo[k*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int NENT  = 64,
  parameter int TAG_W = 52,
  parameter int RPN_W = 44,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [RPN_W-1:0] wr_rpn,
  input  logic             wr_priv,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [RPN_W-1:0] rd_rpn,
  output logic             rd_priv
);
  logic [NENT-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q  [NENT];
  logic [RPN_W-1:0] rpn_q  [NENT];
  logic             priv_q [NENT];

  // Valid bits: whole flush dominates; a single clear after install wins.
  always_comb begin
    vld_d = vld_q;
    if (clr_all) begin
      vld_d = '0;
    end else begin
      if (wr_en)  vld_d[wr_idx]  = 1'b1;
      if (clr_en) vld_d[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload carries no reset; its validity is tracked by vld_q.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      rpn_q[wr_idx]  <= wr_rpn;
      priv_q[wr_idx] <= wr_priv;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_rpn   = rpn_q[rd_idx];
  assign rd_priv  = priv_q[rd_idx];
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int RA_W  = 56,
  parameter int PG_SH = 12,
  localparam int TAG_W = EA_W - PG_SH,
  localparam int RPN_W = RA_W - PG_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [EA_W-1:0]  req_ea,
  input  fmode_t           mode,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [RPN_W-1:0] ent_rpn,
  input  logic             ent_priv,
  output logic             rsp_valid,
  output logic [RA_W-1:0]  rsp_ra,
  output logic             rsp_fail
);
  logic            hit, priv_block;
  logic [RA_W-1:0] ra_d;
  logic            fail_d;

  always_comb begin
    hit        = ent_valid && (ent_tag == req_ea[EA_W-1:PG_SH]);
    priv_block = ent_priv && !mode.priv;
    if (!mode.virt) begin
      ra_d   = req_ea[RA_W-1:0];
      fail_d = 1'b0;
    end else if (hit && !priv_block) begin
      ra_d   = {ent_rpn, req_ea[PG_SH-1:0]};
      fail_d = 1'b0;
    end else begin
      ra_d   = '0;
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_ra   <= ra_d;
      rsp_fail <= fail_d;
    end
  end
endmodule

// File: rtl/itlb_hashed_dm.sv
module itlb_hashed_dm
  import itlb_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int RA_W  = 56,
  parameter int PG_SH = 12,
  parameter int NENT  = 64,
  parameter int NFOLD = 3,
  localparam int IDX_W = $clog2(NENT),
  localparam int HW    = IDX_W * NFOLD,
  localparam int TAG_W = EA_W - PG_SH,
  localparam int RPN_W = RA_W - PG_SH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect,
  input  logic            redir_virt,
  input  logic            redir_priv,
  input  logic            req_valid,
  input  logic [EA_W-1:0] req_ea,
  output logic            rsp_valid,
  output logic [RA_W-1:0] rsp_ra,
  output logic            rsp_fail,
  input  logic            ins_valid,
  input  logic [EA_W-1:0] ins_ea,
  input  logic [63:0]     ins_pte,
  input  logic            inv_valid,
  input  logic [EA_W-1:0] inv_ea,
  input  logic            inv_all
);
  localparam int NSRC = 3;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Mode flags: only a redirect updates them; it applies in its own cycle.
  fmode_t mode_q, mode_eff;
  always_comb begin
    mode_eff = mode_q;
    if (redirect) mode_eff = '{virt: redir_virt, priv: redir_priv};
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= '{virt: 1'b0, priv: 1'b1};
    else            mode_q <= mode_eff;
  end

  // One hash per address source: 0 lookup, 1 install, 2 invalidate.
  logic [EA_W-1:0]  src_ea  [NSRC];
  logic [IDX_W-1:0] src_idx [NSRC];
  assign src_ea[0] = req_ea;
  assign src_ea[1] = ins_ea;
  assign src_ea[2] = inv_ea;

  for (genvar g = 0; g < NSRC; g++) begin : g_hash
    itlb_hash #(.IDX_W(IDX_W), .NFOLD(NFOLD)) hash_i (
      .vpn_lo (src_ea[g][PG_SH +: HW]),
      .idx    (src_idx[g])
    );
  end

  // Insertion filter: entries that could never allow execution are refused.
  logic ins_ok;
  assign ins_ok = ins_valid && ins_pte[PTE_EXEC_BIT] && ins_pte[PTE_REF_BIT];

  logic             ent_valid, ent_priv;
  logic [TAG_W-1:0] ent_tag;
  logic [RPN_W-1:0] ent_rpn;

  itlb_store #(.NENT(NENT), .TAG_W(TAG_W), .RPN_W(RPN_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (ins_ok),
    .wr_idx   (src_idx[1]),
    .wr_tag   (ins_ea[EA_W-1:PG_SH]),
    .wr_rpn   (ins_pte[RA_W-1:PG_SH]),
    .wr_priv  (ins_pte[PTE_PRIV_BIT]),
    .clr_en   (inv_valid),
    .clr_idx  (src_idx[2]),
    .clr_all  (inv_all),
    .rd_idx   (src_idx[0]),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_rpn   (ent_rpn),
    .rd_priv  (ent_priv)
  );

  itlb_xlate #(.EA_W(EA_W), .RA_W(RA_W), .PG_SH(PG_SH)) xlate_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ea    (req_ea),
    .mode      (mode_eff),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_rpn   (ent_rpn),
    .ent_priv  (ent_priv),
    .rsp_valid (rsp_valid),
    .rsp_ra    (rsp_ra),
    .rsp_fail  (rsp_fail)
  );
endmodule

// File: rtl/itlb_hashed_dm_chk.sv
module itlb_hashed_dm_chk #(
  parameter int EA_W = 64,
  parameter int RA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redirect,
  input logic            redir_virt,
  input logic            req_valid,
  input logic [EA_W-1:0] req_ea,
  input logic            inv_all,
  input logic            rsp_valid,
  input logic [RA_W-1:0] rsp_ra,
  input logic            rsp_fail
);
  logic virt_sh_q, virt_eff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        virt_sh_q <= 1'b0;
    else if (redirect) virt_sh_q <= redir_virt;
  end
  assign virt_eff = redirect ? redir_virt : virt_sh_q;

  // R1: no response while reset is applied
  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!rsp_valid);
  end

  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_real_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !virt_eff) |=> (!rsp_fail && rsp_ra == $past(req_ea[RA_W-1:0])));
  a_r5_fail_zero_ra: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |-> (rsp_ra == '0));
  a_r9_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && req_valid && virt_eff) |=> rsp_fail);
endmodule

bind itlb_hashed_dm itlb_hashed_dm_chk #(.EA_W(EA_W), .RA_W(RA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .redirect   (redirect),
  .redir_virt (redir_virt),
  .req_valid  (req_valid),
  .req_ea     (req_ea),
  .inv_all    (inv_all),
  .rsp_valid  (rsp_valid),
  .rsp_ra     (rsp_ra),
  .rsp_fail   (rsp_fail)
);

// File: tb/itlb_hashed_dm_tb_top.sv
module itlb_hashed_dm_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 0, redir_virt = 0, redir_priv = 0;
  logic        req_valid = 0;
  logic [63:0] req_ea = '0;
  logic        rsp_valid, rsp_fail;
  logic [55:0] rsp_ra;
  logic        ins_valid = 0;
  logic [63:0] ins_ea = '0, ins_pte = '0;
  logic        inv_valid = 0;
  logic [63:0] inv_ea = '0;
  logic        inv_all = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itlb_hashed_dm dut_i (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redir_virt(redir_virt),
    .redir_priv(redir_priv), .req_valid(req_valid), .req_ea(req_ea),
    .rsp_valid(rsp_valid), .rsp_ra(rsp_ra), .rsp_fail(rsp_fail),
    .ins_valid(ins_valid), .ins_ea(ins_ea), .ins_pte(ins_pte),
    .inv_valid(inv_valid), .inv_ea(inv_ea), .inv_all(inv_all)
  );

  int total = 0, bad = 0;

  // Behavioural reference: slot number -> stored page contents
  bit [51:0] m_tag [int];
  bit [43:0] m_rpn [int];
  bit        m_prv [int];
  bit        m_virt = 0, m_priv = 1;

  // Stimulus for the next cycle
  bit        s_redir, s_rv, s_rp, s_req, s_ins, s_inv, s_all;
  bit [63:0] s_ea, s_iea, s_pte, s_vea;
  string     s_tag = "R12";

  function automatic int bh(bit [63:0] ea);
    return int'(((ea >> 12) ^ (ea >> 18) ^ (ea >> 24)) & 64'd63);
  endfunction

  task automatic chk(string r, bit ok, logic [55:0] a_ra, logic a_f,
                     logic [55:0] e_ra, logic e_f);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: ra=%h fail=%b expected ra=%h fail=%b", r, a_ra, a_f, e_ra, e_f);
    end
  endtask

  task automatic tick();
    bit          e_v, e_f, ev, ep;
    bit   [55:0] e_ra;
    int          ix;
    @(negedge clk);
    redirect = s_redir; redir_virt = s_rv; redir_priv = s_rp;
    req_valid = s_req; req_ea = s_ea;
    ins_valid = s_ins; ins_ea = s_iea; ins_pte = s_pte;
    inv_valid = s_inv; inv_ea = s_vea; inv_all = s_all;
    ev = s_redir ? s_rv : m_virt;
    ep = s_redir ? s_rp : m_priv;
    e_v = s_req; e_f = 0; e_ra = '0;
    if (s_req) begin
      if (!ev) e_ra = s_ea[55:0];
      else begin
        ix = bh(s_ea);
        if (m_tag.exists(ix) && m_tag[ix] == s_ea[63:12] && !(m_prv[ix] && !ep))
          e_ra = {m_rpn[ix], s_ea[11:0]};
        else e_f = 1;
      end
    end
    if (s_redir) begin m_virt = s_rv; m_priv = s_rp; end
    if (s_all) begin
      m_tag.delete(); m_rpn.delete(); m_prv.delete();
    end else begin
      if (s_ins && s_pte[0] && s_pte[8]) begin
        ix = bh(s_iea);
        m_tag[ix] = s_iea[63:12]; m_rpn[ix] = s_pte[55:12]; m_prv[ix] = s_pte[3];
      end
      if (s_inv) begin
        ix = bh(s_vea);
        if (m_tag.exists(ix)) begin m_tag.delete(ix); m_rpn.delete(ix); m_prv.delete(ix); end
      end
    end
    @(posedge clk); #1;
    chk("R12", rsp_valid == e_v, rsp_ra, rsp_fail, e_ra, e_f);
    if (e_v) chk(s_tag, rsp_ra == e_ra && rsp_fail == e_f, rsp_ra, rsp_fail, e_ra, e_f);
    s_redir = 0; s_req = 0; s_ins = 0; s_inv = 0; s_all = 0; s_tag = "R12";
  endtask

  task automatic look(bit [63:0] ea, string t);
    s_req = 1; s_ea = ea; s_tag = t; tick();
  endtask
  task automatic put(bit [63:0] ea, bit [63:0] pte);
    s_ins = 1; s_iea = ea; s_pte = pte; tick();
  endtask
  task automatic redir(bit v, bit p);
    s_redir = 1; s_rv = v; s_rp = p;
  endtask

  localparam bit [63:0] PA = 64'h0000_0000_0040_3000;
  localparam bit [63:0] PB = 64'h0000_0000_0044_2000; // same slot as PA
  localparam bit [63:0] PC = 64'h0000_0000_0123_4000;
  localparam bit [63:0] PD = 64'h0000_0007_8800_5000;

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", rsp_valid == 0, rsp_ra, rsp_fail, '0, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    tick();                                          // R1 idle, no response
    look(64'h1234_5678_9abc_def0, "R2");             // untranslated reset mode
    redir(1, 1); look(PA | 64'h10, "R1");            // empty table: miss (R5)
    put(PA, 64'h0000_0012_3456_7101);
    look(PA | 64'h44, "R4");
    look(PA + 64'hffc, "R4");
    look(PB, "R3");                                  // alias, tag differs: miss
    put(PB, 64'h00ab_cdef_0123_4101);
    look(PA, "R3");                                  // displaced
    look(PB | 64'h8, "R3");
    s_inv = 1; s_vea = PA; tick();                   // tag-blind clear of PB's slot
    look(PB, "R8");
    put(PC, 64'h0000_0000_0999_9100);                // no execute
    look(PC, "R7");
    put(PC, 64'h0000_0000_0999_9001);                // not referenced
    look(PC, "R7");
    put(PC, 64'h0000_0000_0999_9101);
    look(PC | 64'h20, "R7");
    put(PD, 64'h0000_0055_5555_5109);                // supervisor-only
    look(PD, "R6");
    redir(1, 0); look(PD, "R6");                     // problem state: fail
    look(PC, "R6");
    s_rv = 1; s_rp = 1; look(PD, "R10");             // no redirect: ignored
    redir(0, 1); look(PD | 64'h123, "R10");
    look(64'hffff_ffff_ffff_fffc, "R2");
    redir(1, 1); look(PC, "R10");
    s_ins = 1; s_iea = PA; s_pte = 64'h0000_0000_0777_7101;
    s_inv = 1; s_vea = PB; tick();                   // same slot: clear wins
    look(PA, "R11");
    s_ins = 1; s_iea = PA; s_pte = 64'h0000_0000_0777_7101;
    look(PA, "R11");                                 // sees the old (empty) slot
    look(PA, "R11");
    s_all = 1; s_ins = 1; s_iea = PB; s_pte = 64'h0000_0000_0111_1101; tick();
    look(PA, "R9");
    look(PC, "R9");
    look(PD, "R9");
    look(PB, "R9");
    put(PC, 64'h0000_0000_0999_9101);
    s_all = 1; look(PC, "R9");                        // flush lands after this lookup
    look(PC, "R9");
    repeat (2) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule